// File: doc/BRIEF.md
# Edge-Stepped Contrast Code Register

This block keeps the code word that selects the contrast level of a display bias converter. Two asynchronous, idle-high strobes adjust it: a high-to-low transition on the raise strobe moves the code one count up, and a high-to-low transition on the lower strobe moves it one count down. Both strobes are brought into the system clock domain through synchronizers before their edges are detected. Holding both strobes low at once returns the code to midscale, which is also the value it takes out of reset.

A separate active-low shutdown input is synchronized and presented as an analog-enable flag. Shutdown does not freeze or clear the code. Strobes keep working while the analog section is off, so the code that was set last is ready when the section is turned back on. The strobes are assumed to be clean logic signals, so the block does not debounce them.

Top module: `contrast_code_reg`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `code` equals midscale (32 for the default 6-bit width) and `analog_en` is 0.
- R2: A falling edge on `raise_n` while `lower_n` stays high increases `code` by exactly one.
- R3: A falling edge on `lower_n` while `raise_n` stays high decreases `code` by exactly one.
- R4: A raise step when `code` is 63 leaves `code` at 63 and never wraps to 0.
- R5: A lower step when `code` is 0 leaves `code` at 0 and never wraps to 63.
- R6: When both strobes are low at the synchronized sampling point, `code` is forced to midscale. This overrides any edge in the same cycle, including falls on both strobes together.
- R7: Rising edges of either strobe never change `code`, and `code` only changes in a cycle that follows a low level on at least one strobe.
- R8: After a strobe falls, `code` changes on the third rising clock edge. `analog_en` follows `shutdown_n` two rising clock edges later.
- R9: While `shutdown_n` is low, `code` keeps its value and still responds to strobes, and that value stays in place when the section is enabled again.
- R10: Each falling edge counts as one step, including a low pulse that lasts only one clock period, provided each low and high level lasts at least one clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_n | input | 1 | Asynchronous idle-high strobe; a falling edge steps the code up |
| lower_n | input | 1 | Asynchronous idle-high strobe; a falling edge steps the code down |
| shutdown_n | input | 1 | Asynchronous active-low disable for the analog contrast section |
| code | output | CODE_W (6) | Current contrast code |
| analog_en | output | 1 | Synchronized enable flag for the analog section |

## Verification
The stepping function is driven in four ways:
- Single raise and lower pulses of random widths confirm that each edge counts exactly once.
- Long directed runs toward each end separate saturating behaviour from wraparound.
- Simultaneous and staggered double-low patterns confirm that the midscale force wins over the edges around it and that releasing the strobes causes no step.
- A latency probe fixes the exact cycle in which the code moves.

Shutdown toggles are mixed into the random sequence to show that the code survives a disabled period untouched.

// File: rtl/ccr_pkg.sv
// Shared types for the contrast code register.
// Assumes: nothing beyond SystemVerilog 2017 packages.
package ccr_pkg;

    // Update chosen for the code register in a given cycle.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2,
        OP_MID  = 2'd3
    } step_op_e;

endpackage

// File: rtl/ccr_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the reset value is the input's idle level.
module ccr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ccr_fall_detect.sv
// Synchronizes an idle-high strobe and flags its high-to-low transitions.
// Assumes: the strobe is a clean logic signal, and each level lasts at least one clock period.
module ccr_fall_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic level,
    output logic fall
);
    logic synced;
    logic prev;

    ccr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (strobe_n),
        .q     (synced)
    );

    // Remember last cycle's synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= synced;
    end

    assign level = synced;
    assign fall  = prev & ~synced;
endmodule

// File: rtl/ccr_step_ctrl.sv
// Picks the update for the code register from strobe levels and edges.
// Priority: both strobes low forces midscale, then a single fall steps the code, otherwise it holds.
// Assumes: inputs are already synchronized.
module ccr_step_ctrl
    import ccr_pkg::*;
(
    input  logic     up_level,
    input  logic     up_fall,
    input  logic     dn_level,
    input  logic     dn_fall,
    output step_op_e op
);
    // Priority decode of the step operation.
    always_comb begin
        if (!up_level && !dn_level)  op = OP_MID;
        else if (up_fall && !dn_fall) op = OP_INC;
        else if (dn_fall && !up_fall) op = OP_DEC;
        else                          op = OP_HOLD;
    end
endmodule

// File: rtl/ccr_code_reg.sv
// Saturating code register that starts at midscale.
// Assumes: CODE_W >= 2; the op input is stable and synchronous to clk.
module ccr_code_reg
    import ccr_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_op_e          op,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] MIN_CODE = '0;

    logic [CODE_W-1:0] next_code;

    // Next value with saturation at both ends.
    always_comb begin
        next_code = code;
        unique case (op)
            OP_MID:  next_code = MID_CODE;
            OP_INC:  if (code != MAX_CODE) next_code = code + CODE_W'(1);
            OP_DEC:  if (code != MIN_CODE) next_code = code - CODE_W'(1);
            default: next_code = code;
        endcase
    end

    // Hold the code; midscale out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) code <= MID_CODE;
        else        code <= next_code;
    end
endmodule

// File: rtl/contrast_code_reg.sv
// Top level: two strobe edge detectors, step decoder, code register, shutdown flag sync.
// Assumes: strobes idle high and are debounced elsewhere; shutdown_n is asynchronous.
module contrast_code_reg
    import ccr_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_n,
    input  logic              lower_n,
    input  logic              shutdown_n,
    output logic [CODE_W-1:0] code,
    output logic              analog_en
);
    localparam int N_STROBES = 2;

    logic [N_STROBES-1:0] strobe_in;
    logic [N_STROBES-1:0] lvl;
    logic [N_STROBES-1:0] fal;
    step_op_e             op;

    assign strobe_in = {lower_n, raise_n};

    // One synchronizer and edge detector for each strobe (index 0 raise, 1 lower).
    for (genvar i = 0; i < N_STROBES; i++) begin : g_strobe
        ccr_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_fd (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_n (strobe_in[i]),
            .level    (lvl[i]),
            .fall     (fal[i])
        );
    end

    ccr_step_ctrl u_ctrl (
        .up_level (lvl[0]),
        .up_fall  (fal[0]),
        .dn_level (lvl[1]),
        .dn_fall  (fal[1]),
        .op       (op)
    );

    ccr_code_reg #(.CODE_W(CODE_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .code  (code)
    );

    ccr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (shutdown_n),
        .q     (analog_en)
    );
endmodule

// File: rtl/ccr_checker.sv
// Property checker for contrast_code_reg, attached with bind.
// Assumes the default two-stage synchronizers.
module ccr_checker #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              raise_n,
    input logic              lower_n,
    input logic              shutdown_n,
    input logic [CODE_W-1:0] code,
    input logic              analog_en
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

    // R1
    reset_mid_chk: assert property (@(posedge clk) !rst_n |=> (code == MID_CODE && !analog_en));

    // R2 R3 R6
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |->
            (code == MID_CODE || code == $past(code) + CODE_W'(1) || code == $past(code) - CODE_W'(1)));

    // R4
    no_wrap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code) == MAX_CODE) |-> (code != '0));

    // R5
    no_wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code) == '0) |-> (code != MAX_CODE));

    // R7
    change_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n) && code != $past(code)) |->
            (!$past(raise_n, 3) || !$past(lower_n, 3)));

    // R8
    enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n)) |-> (analog_en == $past(shutdown_n, 2)));
endmodule

bind contrast_code_reg ccr_checker #(.CODE_W(CODE_W)) u_ccr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise_n    (raise_n),
    .lower_n    (lower_n),
    .shutdown_n (shutdown_n),
    .code       (code),
    .analog_en  (analog_en)
);

// File: tb/contrast_code_reg_bench.sv
module contrast_code_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raise_n = 1'b1;
    logic       lower_n = 1'b1;
    logic       shutdown_n = 1'b0;
    logic [5:0] code;
    logic       analog_en;

    int checks = 0;
    int fails  = 0;
    int exp_code = 32;

    always #2.5 clk = ~clk;

    contrast_code_reg u_contrast_code_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_n    (raise_n),
        .lower_n    (lower_n),
        .shutdown_n (shutdown_n),
        .code       (code),
        .analog_en  (analog_en)
    );

    function automatic int model_inc(int c);
        return (c >= 63) ? 63 : c + 1;
    endfunction

    function automatic int model_dec(int c);
        return (c <= 0) ? 0 : c - 1;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Low pulse on raise_n, then settle and check.
    task automatic pulse_up(int w, string req);
        raise_n = 1'b0; idle(w);
        raise_n = 1'b1; idle(4);
        exp_code = model_inc(exp_code);
        check(req, code, exp_code);
    endtask

    task automatic pulse_dn(int w, string req);
        lower_n = 1'b0; idle(w);
        lower_n = 1'b1; idle(4);
        exp_code = model_dec(exp_code);
        check(req, code, exp_code);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h1357);
        idle(3);
        // R1 reset state
        check("R1 code in reset", code, 32);
        check("R1 enable in reset", analog_en, 0);
        rst_n = 1'b1;
        idle(1);
        check("R1 code after release", code, 32);
        shutdown_n = 1'b1; idle(3);
        check("R8 analog_en high", analog_en, 1);

        // R8 latency probe
        raise_n = 1'b0;
        idle(2);
        check("R8 no change after two edges", code, 32);
        idle(1);
        check("R8 change on third edge", code, 33);
        raise_n = 1'b1; idle(4);
        check("R7 release causes no step", code, 33);
        exp_code = 33;

        // R2 R3 basic steps
        pulse_up(2, "R2 raise step");
        pulse_dn(2, "R3 lower step");
        pulse_dn(1, "R10 one-cycle lower pulse");
        pulse_up(1, "R10 one-cycle raise pulse");

        // R4 saturation high
        for (int i = 0; i < 40; i++) pulse_up(1 + (i % 2), "R4 climb");
        check("R4 stays at max", code, 63);

        // R5 saturation low
        for (int i = 0; i < 70; i++) pulse_dn(1 + (i % 2), "R5 descend");
        check("R5 stays at min", code, 0);

        // R6 simultaneous falls force midscale
        raise_n = 1'b0; lower_n = 1'b0; idle(4);
        check("R6 simultaneous low", code, 32);
        raise_n = 1'b1; idle(4);
        lower_n = 1'b1; idle(4);
        check("R7 staggered release no step", code, 32);
        exp_code = 32;

        // R6 staggered: step, then force
        pulse_up(2, "R2 before stagger");
        raise_n = 1'b0; idle(4);
        check("R2 raise held", code, exp_code + 1);
        lower_n = 1'b0; idle(4);
        check("R6 second strobe forces midscale", code, 32);
        lower_n = 1'b1; raise_n = 1'b1; idle(4);
        check("R7 joint release no step", code, 32);
        exp_code = 32;

        // R9 steps during shutdown
        shutdown_n = 1'b0; idle(3);
        check("R8 analog_en low", analog_en, 0);
        pulse_up(1, "R9 raise while shut down");
        pulse_up(2, "R9 raise while shut down");
        shutdown_n = 1'b1; idle(3);
        check("R9 code kept on enable", code, 34);
        check("R9 enable restored", analog_en, 1);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            int unsigned op = $urandom_range(0, 5);
            int unsigned w  = $urandom_range(1, 3);
            case (op)
                0, 1: pulse_up(w, "R2 random raise");
                2, 3: pulse_dn(w, "R3 random lower");
                4: begin
                    raise_n = 1'b0; lower_n = 1'b0; idle(w + 3);
                    raise_n = 1'b1; lower_n = 1'b1; idle(4);
                    exp_code = 32;
                    check("R6 random force", code, exp_code);
                end
                default: begin
                    shutdown_n = ~shutdown_n; idle(3);
                    check("R8 random enable", analog_en, int'(shutdown_n));
                    check("R9 random code kept", code, exp_code);
                end
            endcase
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule